// File: doc/BRIEF.md
# Vector instruction expansion unit

The unit accepts one decoded register-register instruction at a time and turns it into a run of element instructions, which it pushes into a downstream instruction FIFO. A 32-entry configuration table holds three fields for each architectural register: a flag that marks it as vectorised, a 4-bit element count and a 16-bit per-element enable mask. The count and the mask come from the entry of the instruction's destination register. For element i, every operand whose register is flagged as vectorised is rewritten to its base number plus i, modulo 32. Operands that are not flagged keep the same number in every element. The opcode passes through unchanged.

Both data interfaces use valid/ready. A transfer takes place on a rising clock edge where valid and ready are both high. The input is ready only while the unit is idle, so a second instruction waits until every element of the first has been either handed over or skipped. On the output side, valid stays high and the payload stays frozen until the FIFO raises ready. The element counter stops for as long as the FIFO holds back. When an instruction is accepted, its table fields are copied into the unit. A configuration write therefore affects only instructions that arrive after it.

Top module: `vexp_unit`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0. Every table entry is scalar, with count 0 and mask all ones, so an instruction issued before any configuration comes out as one unchanged element.
- R2: An instruction is accepted on an edge where in_valid and in_ready are both 1. in_ready is 0 from the edge after acceptance until the expansion is complete, so instructions are expanded strictly one after another and in arrival order.
- R3: For element i (counting from 0), an operand whose table flag is 1 is emitted as (base + i) mod 32.
- R4: An operand whose table flag is 0 is emitted with its base number in every element.
- R5: The element count N is taken from the destination register's entry. Elements are produced in ascending order i = 0 .. N-1. A count of 0 yields exactly one element, and that element is issued whatever the mask holds.
- R6: For a count of 1 or more, mask bit i of the destination's entry enables element i. An element whose bit is 0 is never presented on the output, but the elements after it still use their own index i.
- R7: While out_valid is 1 and out_ready is 0, out_valid stays 1 on the next cycle and out_opcode, out_rd, out_rs1 and out_rs2 hold their values.
- R8: A configuration write (cfg_we = 1) updates the entry cfg_reg with cfg_vec, cfg_len and cfg_mask. An instruction already accepted keeps the fields it copied at acceptance.
- R9: out_opcode equals the accepted opcode for every element of that instruction.
- R10: Each element, enabled or skipped, takes at least one cycle. With out_ready held at 1, in_ready returns to 1 exactly max(N,1) cycles after the acceptance edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit idle and able to take an instruction |
| in_opcode | input | 7 | Opcode of the offered instruction |
| in_rd | input | 5 | Destination register |
| in_rs1 | input | 5 | First source register |
| in_rs2 | input | 5 | Second source register |
| cfg_we | input | 1 | Table write strobe |
| cfg_reg | input | 5 | Table entry to write |
| cfg_vec | input | 1 | Vectorised flag for the entry |
| cfg_len | input | 4 | Element count for the entry |
| cfg_mask | input | 16 | Element enable mask for the entry |
| out_valid | output | 1 | Element instruction presented to the FIFO |
| out_ready | input | 1 | FIFO can take an element |
| out_opcode | output | 7 | Element opcode |
| out_rd | output | 5 | Rewritten destination register |
| out_rs1 | output | 5 | Rewritten first source register |
| out_rs2 | output | 5 | Rewritten second source register |

## Verification
The properties assume that the upstream side keeps its instruction fields steady while in_valid is high and not yet accepted. They also assume that out_ready depends only on the FIFO and never on out_valid within the same cycle. Under these conditions, holding the payload, freezing the opcode during an expansion and excluding a new acceptance all follow from the unit's own state. The stimulus drives every input half a cycle away from the active edge. It holds the instruction fields constant until acceptance and never writes a table entry on the same edge on which an instruction that reads that entry is accepted. The bench moves out_ready by a fixed pattern, so the stall sequences can be repeated exactly.

// File: rtl/vexp_pkg.sv
package vexp_pkg;
  parameter int NREG  = 32;
  parameter int RW    = $clog2(NREG);
  parameter int MAXVL = 16;
  parameter int LW    = $clog2(MAXVL);
  parameter int OPW   = 7;
  parameter int NOPND = 3;   // rd, rs1, rs2

  typedef struct packed {
    logic [OPW-1:0] op;
    logic [RW-1:0]  rd;
    logic [RW-1:0]  rs1;
    logic [RW-1:0]  rs2;
  } instr_t;

  typedef struct packed {
    logic             vec;
    logic [LW-1:0]    len;
    logic [MAXVL-1:0] mask;
  } entry_t;
endpackage

// File: rtl/vexp_cfg_table.sv
module vexp_cfg_table
  import vexp_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [RW-1:0]       wr_idx,
  input  entry_t              wr_data,
  input  logic [RW-1:0]       rd_idx [NOPND],
  output logic [NOPND-1:0]    rd_vec,
  output logic [LW-1:0]       dst_len,
  output logic [MAXVL-1:0]    dst_mask
);
  entry_t tab_q [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NREG; k++) begin
        tab_q[k].vec  <= 1'b0;
        tab_q[k].len  <= '0;
        tab_q[k].mask <= '1;
      end
    end else if (wr_en) begin
      tab_q[wr_idx] <= wr_data;
    end
  end

  // Index 0 is the destination; its entry also supplies count and mask.
  for (genvar g = 0; g < NOPND; g++) begin : g_rdport
    assign rd_vec[g] = tab_q[rd_idx[g]].vec;
  end
  assign dst_len  = tab_q[rd_idx[0]].len;
  assign dst_mask = tab_q[rd_idx[0]].mask;
endmodule

// File: rtl/vexp_sequencer.sv
module vexp_sequencer
  import vexp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  instr_t            in_instr,
  input  logic [NOPND-1:0]  in_vec,
  input  logic [LW-1:0]     in_len,
  input  logic [MAXVL-1:0]  in_mask,
  output logic              elem_valid,
  input  logic              elem_ready,
  output logic [LW-1:0]     elem_idx,
  output instr_t            cur_instr,
  output logic [NOPND-1:0]  cur_vec
);
  logic             busy_q;
  logic [LW-1:0]    idx_q;
  logic [LW-1:0]    last_q;
  logic [MAXVL-1:0] mask_q;
  logic             force_q;
  instr_t           instr_q;
  logic [NOPND-1:0] vec_q;
  logic             take;
  logic             gate;
  logic             step;

  assign in_ready = !busy_q;
  assign take     = in_valid && !busy_q;
  assign gate     = force_q || mask_q[idx_q];
  assign step     = busy_q && (!gate || elem_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      last_q  <= '0;
      mask_q  <= '0;
      force_q <= 1'b0;
      instr_q <= '0;
      vec_q   <= '0;
    end else if (take) begin
      busy_q  <= 1'b1;
      idx_q   <= '0;
      last_q  <= (in_len == '0) ? '0 : in_len - 1'b1;
      force_q <= (in_len == '0);
      mask_q  <= in_mask;
      instr_q <= in_instr;
      vec_q   <= in_vec;
    end else if (step) begin
      if (idx_q == last_q) busy_q <= 1'b0;
      else                 idx_q  <= idx_q + 1'b1;
    end
  end

  assign elem_valid = busy_q && gate;
  assign elem_idx   = idx_q;
  assign cur_instr  = instr_q;
  assign cur_vec    = vec_q;
endmodule

// File: rtl/vexp_operand_step.sv
module vexp_operand_step
  import vexp_pkg::*;
(
  input  logic [RW-1:0] base,
  input  logic          vec,
  input  logic [LW-1:0] idx,
  output logic [RW-1:0] reg_out
);
  localparam int SW = (RW > LW) ? RW : LW;
  logic [SW-1:0] sum;

  always_comb begin
    sum     = SW'(base) + SW'(idx);
    reg_out = vec ? sum[RW-1:0] : base;   // mod NREG by truncation
  end
endmodule

// File: rtl/vexp_unit.sv
module vexp_unit
  import vexp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [OPW-1:0]   in_opcode,
  input  logic [RW-1:0]    in_rd,
  input  logic [RW-1:0]    in_rs1,
  input  logic [RW-1:0]    in_rs2,
  input  logic             cfg_we,
  input  logic [RW-1:0]    cfg_reg,
  input  logic             cfg_vec,
  input  logic [LW-1:0]    cfg_len,
  input  logic [MAXVL-1:0] cfg_mask,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OPW-1:0]   out_opcode,
  output logic [RW-1:0]    out_rd,
  output logic [RW-1:0]    out_rs1,
  output logic [RW-1:0]    out_rs2
);
  instr_t           in_instr;
  instr_t           cur_instr;
  entry_t           wr_entry;
  logic [RW-1:0]    look_idx [NOPND];
  logic [RW-1:0]    base_reg [NOPND];
  logic [RW-1:0]    new_reg  [NOPND];
  logic [NOPND-1:0] look_vec;
  logic [NOPND-1:0] cur_vec;
  logic [LW-1:0]    dst_len;
  logic [MAXVL-1:0] dst_mask;
  logic [LW-1:0]    elem_idx;

  assign in_instr = '{op: in_opcode, rd: in_rd, rs1: in_rs1, rs2: in_rs2};
  assign wr_entry = '{vec: cfg_vec, len: cfg_len, mask: cfg_mask};

  assign look_idx[0] = in_rd;
  assign look_idx[1] = in_rs1;
  assign look_idx[2] = in_rs2;

  vexp_cfg_table u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we),
    .wr_idx   (cfg_reg),
    .wr_data  (wr_entry),
    .rd_idx   (look_idx),
    .rd_vec   (look_vec),
    .dst_len  (dst_len),
    .dst_mask (dst_mask)
  );

  vexp_sequencer u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_instr   (in_instr),
    .in_vec     (look_vec),
    .in_len     (dst_len),
    .in_mask    (dst_mask),
    .elem_valid (out_valid),
    .elem_ready (out_ready),
    .elem_idx   (elem_idx),
    .cur_instr  (cur_instr),
    .cur_vec    (cur_vec)
  );

  assign base_reg[0] = cur_instr.rd;
  assign base_reg[1] = cur_instr.rs1;
  assign base_reg[2] = cur_instr.rs2;

  for (genvar g = 0; g < NOPND; g++) begin : g_step
    vexp_operand_step u_step (
      .base    (base_reg[g]),
      .vec     (cur_vec[g]),
      .idx     (elem_idx),
      .reg_out (new_reg[g])
    );
  end

  assign out_opcode = cur_instr.op;
  assign out_rd     = new_reg[0];
  assign out_rs1    = new_reg[1];
  assign out_rs2    = new_reg[2];
endmodule

// File: rtl/vexp_unit_chk.sv
module vexp_unit_chk
  import vexp_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic           out_valid,
  input logic           out_ready,
  input logic [OPW-1:0] out_opcode,
  input logic [RW-1:0]  out_rd,
  input logic [RW-1:0]  out_rs1,
  input logic [RW-1:0]  out_rs2
);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_opcode) &&
      $stable(out_rd) && $stable(out_rs1) && $stable(out_rs2));

  assert_no_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  assert_busy_after_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready);

  assert_opcode_fixed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready && $past(!in_ready) && out_valid && $past(out_valid) |-> $stable(out_opcode));
endmodule

bind vexp_unit vexp_unit_chk u_chk (.*);

// File: tb/tb_vexp_unit.sv
`timescale 1ns/1ps
module tb_vexp_unit;
  import vexp_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [OPW-1:0] in_opcode = '0;
  logic [RW-1:0] in_rd = '0, in_rs1 = '0, in_rs2 = '0;
  logic cfg_we = 1'b0, cfg_vec = 1'b0;
  logic [RW-1:0] cfg_reg = '0;
  logic [LW-1:0] cfg_len = '0;
  logic [MAXVL-1:0] cfg_mask = '0;
  logic out_valid, out_ready = 1'b1;
  logic [OPW-1:0] out_opcode;
  logic [RW-1:0] out_rd, out_rs1, out_rs2;

  always #5 clk = ~clk;

  vexp_unit dut (.*);

  int errors = 0, checks = 0, cycles = 0;
  int tvec [NREG], tlen [NREG], tmask [NREG];
  int log_n = 0;
  int log_op [64], log_rd [64], log_r1 [64], log_r2 [64];
  int exp_n = 0;
  int exp_op [64], exp_rd [64], exp_r1 [64], exp_r2 [64];

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL R2 watchdog: cycles=%0d expected below 100000", cycles);
      finish_run();
    end
    if (rst_n && out_valid && out_ready && log_n < 64) begin
      log_op[log_n] = int'(out_opcode);
      log_rd[log_n] = int'(out_rd);
      log_r1[log_n] = int'(out_rs1);
      log_r2[log_n] = int'(out_rs2);
      log_n = log_n + 1;
    end
  end

  task automatic check(string req, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic cfg_write(int r, int v, int l, int m);
    @(negedge clk);
    cfg_we = 1'b1; cfg_reg = RW'(r); cfg_vec = v[0]; cfg_len = LW'(l); cfg_mask = MAXVL'(m);
    @(negedge clk);
    cfg_we = 1'b0;
    tvec[r] = v; tlen[r] = l; tmask[r] = m;
  endtask

  // Expected elements, derived from the requirements and the bench's own table copy.
  task automatic build_exp(int op, int rd, int r1, int r2);
    int n;
    n = (tlen[rd] == 0) ? 1 : tlen[rd];
    for (int i = 0; i < n; i++) begin
      if (tlen[rd] == 0 || tmask[rd][i]) begin
        exp_op[exp_n] = op;
        exp_rd[exp_n] = tvec[rd] ? (rd + i) % 32 : rd;
        exp_r1[exp_n] = tvec[r1] ? (r1 + i) % 32 : r1;
        exp_r2[exp_n] = tvec[r2] ? (r2 + i) % 32 : r2;
        exp_n++;
      end
    end
  endtask

  task automatic send(int op, int rd, int r1, int r2);
    @(negedge clk);
    in_valid = 1'b1; in_opcode = OPW'(op); in_rd = RW'(rd); in_rs1 = RW'(r1); in_rs2 = RW'(r2);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_idle(output int cnt);
    cnt = 0;
    while (!in_ready && cnt < 500) begin
      @(negedge clk);
      cnt++;
    end
  endtask

  task automatic compare(string req);
    check(req, "element count", log_n, exp_n);
    for (int k = 0; k < exp_n && k < log_n; k++) begin
      check(req, $sformatf("elem %0d opcode", k), log_op[k], exp_op[k]);
      check(req, $sformatf("elem %0d rd", k), log_rd[k], exp_rd[k]);
      check(req, $sformatf("elem %0d rs1", k), log_r1[k], exp_r1[k]);
      check(req, $sformatf("elem %0d rs2", k), log_r2[k], exp_r2[k]);
    end
  endtask

  task automatic run_one(string req, int op, int rd, int r1, int r2);
    int c;
    log_n = 0; exp_n = 0;
    build_exp(op, rd, r1, r2);
    send(op, rd, r1, r2);
    wait_idle(c);
    compare(req);
  endtask

  task automatic t_reset();
    check("R1", "in_ready after reset", int'(in_ready), 1);
    check("R1", "out_valid after reset", int'(out_valid), 0);
    run_one("R1", 7'h33, 7, 4, 4);
  endtask

  task automatic t_all_vector();
    cfg_write(7, 1, 3, 16'hFFFF);
    cfg_write(4, 1, 0, 16'hFFFF);
    run_one("R3", 7'h33, 7, 4, 4);   // r7 r4 r4 / r8 r5 r5 / r9 r6 r6
  endtask

  task automatic t_mixed();
    cfg_write(4, 0, 0, 16'hFFFF);
    cfg_write(1, 1, 0, 16'hFFFF);
    run_one("R4", 7'h21, 7, 4, 1);   // rs1 stays r4, rs2 walks r1..r3
  endtask

  task automatic t_wrap();
    cfg_write(30, 1, 4, 16'hFFFF);
    run_one("R3", 7'h05, 30, 4, 1);  // rd 30,31,0,1
  endtask

  task automatic t_mask();
    int c;
    cfg_write(10, 1, 5, 16'b10110);
    run_one("R6", 7'h11, 10, 1, 4);  // elements 1,2,4 only
    cfg_write(12, 1, 3, 0);
    log_n = 0;
    send(7'h12, 12, 1, 1);
    wait_idle(c);
    check("R6", "pushes with empty mask", log_n, 0);
    check("R10", "cycles with all elements skipped", c, 3);
  endtask

  task automatic t_timing();
    int c;
    cfg_write(13, 0, 3, 16'hFFFF);
    send(7'h01, 13, 2, 3);
    wait_idle(c);
    check("R10", "cycles for three elements", c, 3);
    send(7'h01, 14, 2, 3);           // count 0
    wait_idle(c);
    check("R10", "cycles for count zero", c, 1);
  endtask

  task automatic t_len0_mask();
    cfg_write(15, 1, 0, 0);          // count 0 ignores empty mask
    run_one("R5", 7'h07, 15, 1, 2);
  endtask

  task automatic t_max();
    cfg_write(16, 1, 15, 16'hFFFF);
    run_one("R5", 7'h09, 16, 16, 4);
  endtask

  task automatic t_stall();
    int c, hold_rd, hold_r2;
    cfg_write(20, 1, 4, 16'hFFFF);
    log_n = 0; exp_n = 0;
    build_exp(7'h2A, 20, 4, 1);
    out_ready = 1'b0;
    send(7'h2A, 20, 4, 1);
    hold_rd = int'(out_rd); hold_r2 = int'(out_rs2);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R7", "valid held under stall", int'(out_valid), 1);
      check("R7", "rd held under stall", int'(out_rd), hold_rd);
      check("R7", "rs2 held under stall", int'(out_rs2), hold_r2);
    end
    cfg_write(20, 1, 2, 16'hFFFF);   // in-flight instruction keeps count 4
    for (int k = 0; k < 40 && !in_ready; k++) begin
      out_ready = k[0];
      @(negedge clk);
    end
    out_ready = 1'b1;
    wait_idle(c);
    compare("R7");
    check("R8", "in-flight count after write", log_n, 4);
    run_one("R8", 7'h2A, 20, 4, 1);  // now two elements
  endtask

  task automatic t_back_to_back();
    int c;
    cfg_write(21, 1, 3, 16'hFFFF);
    log_n = 0; exp_n = 0;
    build_exp(7'h31, 21, 2, 3);
    build_exp(7'h32, 7, 4, 1);
    @(negedge clk);
    in_valid = 1'b1; in_opcode = 7'h31; in_rd = 21; in_rs1 = 2; in_rs2 = 3;
    @(negedge clk);
    in_opcode = 7'h32; in_rd = 7; in_rs1 = 4; in_rs2 = 1;  // offered while busy
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    wait_idle(c);
    compare("R2");
  endtask

  initial begin
    for (int k = 0; k < NREG; k++) begin
      tvec[k] = 0; tlen[k] = 0; tmask[k] = 16'hFFFF;
    end
    repeat (3) @(negedge clk);
    t_reset_pre: begin
      check("R1", "in_ready in reset", int'(in_ready), 1);
    end
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_all_vector();
    t_mixed();
    t_wrap();
    t_mask();
    t_timing();
    t_len0_mask();
    t_max();
    t_stall();
    t_back_to_back();
    check("R9", "opcode of last element", log_op[log_n > 0 ? log_n - 1 : 0], 7'h32);
    finish_run();
  end
endmodule